// File: doc/BRIEF.md
# PCI Bus Error Interrupt Monitor

This block observes a shared PCI bus while some other agent is bus master and records five error conditions as sticky flags in a 32-bit status word. The conditions are a data-phase stall in which IRDY stays deasserted for too long, a transaction ended by target abort, a transaction ended by master abort, a parity error on a read, and a parity error on a write. All bus pins are registered once in the bus clock domain before any decision is made. A flag therefore appears in the status word two clocks after the clock on which its pin condition is driven.

The local CPU reads the status word and clears flags through a small register port. The same port holds an interrupt enable mask. The PCI side has a read-only view of the status word. A single interrupt line is raised while any flag that is set is also enabled.

Top module: `pci_err_monitor`

## Requirements
- R1: After reset, the status word, the enable mask and `irq` are all zero.
- R2: Bit 11 sets when, in a foreign transaction, IRDY_n is sampled high on 8 consecutive data-phase clocks. Any clock with IRDY_n low restarts the count, so a run of 7 does not set the bit.
- R3: Bit 3 sets when, in a foreign transaction, STOP_n is low while DEVSEL_n is high during a data-phase clock.
- R4: Bit 2 sets when, in a foreign transaction, FRAME_n returns high on the 5th or a later clock after the address clock and DEVSEL_n has not been low since that address clock. A release on clocks 1 to 4 after the address clock does not set it.
- R5: PERR_n low on a data-phase clock of a foreign transaction sets bit 1 when `bus_cmd_wr` was 0 on the address clock (read), and sets bit 0 when it was 1 (write).
- R6: If `own_master` is high on the address clock, that transaction sets no flag, whatever its pins show.
- R7: A CPU write to address 0 clears every status bit whose `cpu_wdata` bit is 1 and leaves the other bits unchanged.
- R8: If an event and a CPU clear hit the same status bit on the same clock, the bit stays set.
- R9: Only bits 11 and 3 to 0 exist in the status word and in the mask. All other bits read as zero, and writes to them are ignored.
- R10: `pci_rdata` always shows the current status word.
- R11: A CPU write to address 1 loads the enable mask, which reads back at address 1. `irq` is high exactly when the status word ANDed with the mask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_frame_n | input | 1 | FRAME_n from the bus |
| bus_irdy_n | input | 1 | IRDY_n from the bus |
| bus_stop_n | input | 1 | STOP_n from the bus |
| bus_devsel_n | input | 1 | DEVSEL_n from the bus |
| bus_perr_n | input | 1 | PERR_n from the bus |
| bus_cmd_wr | input | 1 | C/BE_n[0] level on the address clock; 1 marks a write command |
| own_master | input | 1 | High while the local controller owns the bus |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 selects status, 1 selects enable mask |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data for the selected register |
| pci_rdata | output | 32 | Read-only status view for the PCI side |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is an event arriving on the very clock that a CPU clear of the same bit takes effect. The bench reaches it by driving a parity error on a data phase and then issuing the clear one clock later, so that the clear write and the registered event meet on the same edge. The stall and master-abort thresholds are also hard to hit by chance. The randomized transactions therefore draw stall lengths and frame-release points that straddle 8 and 5 clocks, and directed cases pin down the exact boundaries.

// File: rtl/pcim_pkg.sv
package pcim_pkg;
    localparam int REG_W   = 32;
    localparam int BIT_TMO = 11;
    localparam int BIT_TA  = 3;
    localparam int BIT_MA  = 2;
    localparam int BIT_RPE = 1;
    localparam int BIT_WPE = 0;
    localparam logic [REG_W-1:0] IMPL_MASK = (REG_W'(1) << BIT_TMO) | REG_W'(4'hF);

    typedef struct packed {
        logic tmo;
        logic ta;
        logic ma;
        logic rpe;
        logic wpe;
    } evt_t;

    // registered copies of the bus pins, active-low levels kept as on the wire
    typedef struct packed {
        logic frame_n;
        logic irdy_n;
        logic stop_n;
        logic devsel_n;
        logic perr_n;
        logic cmd_wr;
        logic local_m;
    } bus_smp_t;

    typedef enum logic {ST_IDLE, ST_DATA} txn_st_e;
endpackage

// File: rtl/pcim_sync.sv
module pcim_sync
    import pcim_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t raw,
    output bus_smp_t smp
);
    localparam bus_smp_t IDLE_BUS = '{frame_n: 1'b1, irdy_n: 1'b1, stop_n: 1'b1,
                                      devsel_n: 1'b1, perr_n: 1'b1, cmd_wr: 1'b0,
                                      local_m: 1'b0};
    bus_smp_t smp_d, smp_q;

    always_comb begin
        smp_d = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= IDLE_BUS;
        else        smp_q <= smp_d;
    end

    assign smp = smp_q;
endmodule

// File: rtl/pcim_detect.sv
module pcim_detect
    import pcim_pkg::*;
#(
    parameter int TMO_CYCLES = 8,
    parameter int ABORT_CLK  = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t smp,
    output evt_t     ev
);
    localparam int TMO_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam int AGE_W = $clog2(ABORT_CLK + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);
    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(ABORT_CLK);

    typedef struct packed {
        txn_st_e          st;
        logic             foreign;
        logic             is_wr;
        logic             dev_seen;
        logic [AGE_W-1:0] age;
        logic [TMO_W-1:0] tmo_cnt;
        logic             tmo_done;
    } trk_t;

    trk_t trk_d, trk_q;
    evt_t ev_d;

    always_comb begin
        trk_d = trk_q;
        ev_d  = '0;
        unique case (trk_q.st)
            ST_IDLE: begin
                if (!smp.frame_n) begin
                    trk_d.st       = ST_DATA;
                    trk_d.foreign  = !smp.local_m;
                    trk_d.is_wr    = smp.cmd_wr;
                    trk_d.dev_seen = 1'b0;
                    trk_d.age      = AGE_W'(1);
                    trk_d.tmo_cnt  = '0;
                    trk_d.tmo_done = 1'b0;
                end
            end
            ST_DATA: begin
                if (smp.frame_n && smp.irdy_n) begin
                    trk_d.st = ST_IDLE;
                end else begin
                    if (trk_q.age < AGE_MAX) trk_d.age = trk_q.age + AGE_W'(1);
                    if (!smp.devsel_n) trk_d.dev_seen = 1'b1;
                    if (trk_q.foreign) begin
                        ev_d.ta  = !smp.stop_n && smp.devsel_n;
                        ev_d.ma  = smp.frame_n && smp.devsel_n && !trk_q.dev_seen
                                   && (trk_q.age >= AGE_MAX);
                        ev_d.rpe = !smp.perr_n && !trk_q.is_wr;
                        ev_d.wpe = !smp.perr_n && trk_q.is_wr;
                        if (!smp.irdy_n) begin
                            trk_d.tmo_cnt = '0;
                        end else if (!trk_q.tmo_done) begin
                            if (trk_q.tmo_cnt == TMO_LAST) begin
                                ev_d.tmo       = 1'b1;
                                trk_d.tmo_done = 1'b1;
                            end else begin
                                trk_d.tmo_cnt = trk_q.tmo_cnt + TMO_W'(1);
                            end
                        end
                    end
                end
            end
            default: trk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{st: ST_IDLE, default: '0};
        else        trk_q <= trk_d;
    end

    assign ev = ev_d;

    // a stall is reported once per transaction
    assert_tmo_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev.tmo |=> !ev.tmo);

    // a locally mastered transaction never raises an event
    assert_local_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == ST_DATA && !trk_q.foreign) |-> (ev == '0));
endmodule

// File: rtl/pcim_status.sv
module pcim_status
    import pcim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             ev,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] mask,
    output logic             irq
);
    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] mask;
    } st_reg_t;

    st_reg_t          reg_d, reg_q;
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        ev_vec          = '0;
        ev_vec[BIT_TMO] = ev.tmo;
        ev_vec[BIT_TA]  = ev.ta;
        ev_vec[BIT_MA]  = ev.ma;
        ev_vec[BIT_RPE] = ev.rpe;
        ev_vec[BIT_WPE] = ev.wpe;
        clr_vec         = clr_we ? (wdata & IMPL_MASK) : '0;

        reg_d      = reg_q;
        reg_d.stat = (reg_q.stat & ~clr_vec) | ev_vec;
        if (mask_we) reg_d.mask = wdata & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign stat = reg_q.stat;
    assign mask = reg_q.mask;
    assign irq  = |(reg_q.stat & reg_q.mask);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat & $past(wdata & IMPL_MASK & ~ev_vec)) == '0));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(stat & ~clr_vec)) == $past(stat & ~clr_vec)));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vec) |=> ((stat & $past(ev_vec)) == $past(ev_vec)));
endmodule

// File: rtl/pci_err_monitor.sv
module pci_err_monitor
    import pcim_pkg::*;
#(
    parameter int TMO_CYCLES = 8,
    parameter int ABORT_CLK  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_frame_n,
    input  logic              bus_irdy_n,
    input  logic              bus_stop_n,
    input  logic              bus_devsel_n,
    input  logic              bus_perr_n,
    input  logic              bus_cmd_wr,
    input  logic              own_master,
    input  logic              cpu_we,
    input  logic              cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic [REG_W-1:0]  pci_rdata,
    output logic              irq
);
    bus_smp_t         raw, smp;
    evt_t             ev;
    logic [REG_W-1:0] stat, mask;

    always_comb begin
        raw.frame_n  = bus_frame_n;
        raw.irdy_n   = bus_irdy_n;
        raw.stop_n   = bus_stop_n;
        raw.devsel_n = bus_devsel_n;
        raw.perr_n   = bus_perr_n;
        raw.cmd_wr   = bus_cmd_wr;
        raw.local_m  = own_master;
    end

    pcim_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .smp   (smp)
    );

    pcim_detect #(
        .TMO_CYCLES (TMO_CYCLES),
        .ABORT_CLK  (ABORT_CLK)
    ) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .ev    (ev)
    );

    pcim_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .clr_we  (cpu_we && !cpu_addr),
        .mask_we (cpu_we && cpu_addr),
        .wdata   (cpu_wdata),
        .stat    (stat),
        .mask    (mask),
        .irq     (irq)
    );

    assign cpu_rdata = cpu_addr ? mask : stat;
    assign pci_rdata = stat;

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdata & ~IMPL_MASK) == '0);
endmodule

// File: tb/pci_err_monitor_tb.sv
`timescale 1ns/1ps
module pci_err_monitor_tb;
    localparam logic [31:0] IMPL = 32'h0000_080F;
    localparam logic [31:0] F_TMO = 32'h800, F_TA = 32'h8, F_MA = 32'h4,
                            F_RPE = 32'h2, F_WPE = 32'h1;

    logic clk = 1'b0;
    logic rst_n;
    logic frame_n, irdy_n, stop_n, devsel_n, perr_n, cmd_wr, own;
    logic cpu_we, cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata, pci_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_st = '0;
    logic [31:0] exp_mask = '0;

    always #2.5 clk = ~clk;

    pci_err_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_frame_n(frame_n), .bus_irdy_n(irdy_n), .bus_stop_n(stop_n),
        .bus_devsel_n(devsel_n), .bus_perr_n(perr_n), .bus_cmd_wr(cmd_wr),
        .own_master(own), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pci_rdata(pci_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        cpu_addr = 1'b0;
        #1;
        chk(req, cpu_rdata, exp_st);
        chk("R10 pci view", pci_rdata, exp_st);
        chk("R11 irq", {31'b0, irq}, {31'b0, |(exp_st & exp_mask)});
        cpu_addr = 1'b1;
        #1;
        chk("R11 mask readback", cpu_rdata, exp_mask);
        cpu_addr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus(input logic f, input logic i, input logic d, input logic s, input logic p);
        frame_n = f; irdy_n = i; devsel_n = d; stop_n = s; perr_n = p;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) bus(1, 1, 1, 1, 1);
        own = 1'b0;
    endtask

    task automatic start(input bit foreign, input bit wr);
        own = !foreign;
        cmd_wr = wr;
        bus(0, 1, 1, 1, 1);
    endtask

    task automatic cpu_write(input logic a, input logic [31:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (!a) exp_st = exp_st & ~(d & IMPL);
        else    exp_mask = d & IMPL;
    endtask

    // bench model of each transaction shape
    task automatic t_clean(input bit foreign, input bit wr, input int len, input int perr_at);
        start(foreign, wr);
        for (int k = 1; k <= len; k++) bus(k == len, 0, 0, 1, (k == perr_at) ? 1'b0 : 1'b1);
        idle(3);
        if (foreign && perr_at >= 1 && perr_at <= len) exp_st |= wr ? F_WPE : F_RPE;
    endtask

    task automatic t_gap(input bit foreign, input int g1, input int g2);
        start(foreign, 1'b0);
        repeat (g1) bus(0, 1, 0, 1, 1);
        if (g2 > 0) begin
            bus(0, 0, 0, 1, 1);
            repeat (g2) bus(0, 1, 0, 1, 1);
        end
        bus(1, 0, 0, 1, 1);
        idle(3);
        if (foreign && (g1 >= 8 || g2 >= 8)) exp_st |= F_TMO;
    endtask

    task automatic t_ma(input bit foreign, input int h);
        start(foreign, 1'b0);
        repeat (h) bus(0, 0, 1, 1, 1);
        bus(1, 0, 1, 1, 1);
        idle(3);
        if (foreign && h + 1 >= 5) exp_st |= F_MA;
    endtask

    task automatic t_ta(input bit foreign);
        start(foreign, 1'b1);
        bus(0, 0, 0, 1, 1);
        bus(1, 0, 1, 0, 1);
        idle(3);
        if (foreign) exp_st |= F_TA;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; own = 1'b0; cmd_wr = 1'b0;
        frame_n = 1; irdy_n = 1; stop_n = 1; devsel_n = 1; perr_n = 1;
        cpu_we = 0; cpu_addr = 0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        cpu_write(1'b1, 32'hFFFF_FFFF);
        check_all("R9 mask reserved bits");

        t_gap(1, 7, 0);  check_all("R2 seven stalls");
        t_gap(1, 5, 6);  check_all("R2 count restart");
        t_gap(1, 8, 0);  check_all("R2 eight stalls");
        cpu_write(1'b0, F_TMO); check_all("R7 clear tmo");

        t_ma(1, 3); check_all("R4 early release");
        t_ma(1, 4); check_all("R4 fifth clock");
        t_ta(1);    check_all("R3 target abort");
        t_clean(1, 0, 3, 2); check_all("R5 read parity");
        t_clean(1, 1, 2, 1); check_all("R5 write parity");

        cpu_write(1'b0, 32'hFFFF_FFFF); check_all("R9 status clear all");
        t_ta(0); t_ma(0, 6); t_gap(0, 10, 0); t_clean(0, 1, 3, 2);
        check_all("R6 local master quiet");

        t_clean(1, 0, 1, 1); t_ta(1);
        check_all("R7 setup");
        cpu_write(1'b0, F_WPE | F_MA); check_all("R7 clear of unset bits");

        // collision: parity event and clear of the same bit meet on one edge
        own = 1'b0; cmd_wr = 1'b0;
        bus(0, 1, 1, 1, 1);
        frame_n = 1; irdy_n = 0; devsel_n = 0; stop_n = 1; perr_n = 0;
        @(negedge clk);
        frame_n = 1; irdy_n = 1; devsel_n = 1; perr_n = 1;
        cpu_addr = 1'b0; cpu_wdata = F_RPE | F_TA; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        idle(2);
        exp_st = (exp_st & ~F_TA) | F_RPE;
        check_all("R8 set wins over clear");

        cpu_write(1'b1, F_TA); check_all("R11 irq masked off");
        cpu_write(1'b1, F_RPE); check_all("R11 irq enabled");

        for (int n = 0; n < 250; n++) begin
            int sh;
            bit fo;
            sh = int'($urandom % 4);
            fo = ($urandom % 4) != 0;
            case (sh)
                0: t_clean(fo, 1'(($urandom % 2)), 1 + int'($urandom % 5), int'($urandom % 6));
                1: t_gap(fo, int'($urandom % 12), int'($urandom % 11));
                2: t_ma(fo, 1 + int'($urandom % 7));
                default: t_ta(fo);
            endcase
            check_all("R2 R3 R4 R5 R6 random");
            if ($urandom % 3 == 0) begin
                cpu_write(1'b0, $urandom);
                check_all("R7 random clear");
            end
            if ($urandom % 5 == 0) begin
                cpu_write(1'b1, $urandom);
                check_all("R11 random mask");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule